// File: doc/BRIEF.md
# Periodic Successive-Approximation Converter Sequencer

This block is the digital side of an 8-bit successive-approximation converter that serves three analog inputs. A two-bit select input picks one of the inputs or powers the converter down. While an input is selected, a free-running scheduler starts a conversion once per period, which is 10 ms at the intended clock rate. For each conversion the block latches the chosen input number onto the analog multiplexer select. It then runs a binary search on an 8-bit trial code driven to an external DAC. It reads a one-bit comparator answer once per clock.

The multiplexer, the DAC and the comparator sit outside the block and appear only as ports. The comparator answers 1 when the selected input is at or above the trial code. The finished code is written to the result output in a single step, and a one-cycle done pulse marks the write. A change of selection is applied at the next scheduled conversion. Powering down in the middle of a conversion aborts it, and the previous result is kept.

The period parameter `TICK_CYCLES` must be at least `DATA_W + 1`, so that a conversion always ends before the next start.

Top module: `adc_sar_seq`

## Requirements
- R1: `pdn_o` is 1 exactly while `sel_i` is 2'b00, and no conversion starts or completes while it is 1.
- R2: Select codes 2'b01, 2'b10 and 2'b11 drive `mux_sel_o` to 0, 1 and 2 for the whole of a conversion started under that code.
- R3: Conversions start every `TICK_CYCLES` enabled clocks. After the converter is enabled, the first `done_o` appears on the (`TICK_CYCLES`+8)-th rising edge. Each later one follows exactly `TICK_CYCLES` edges after the one before.
- R4: A conversion drives `dac_code_o` with one trial per clock, testing bits 7 down to 0. The first trial is 8'h80. A tested bit stays 1 only when `cmp_i` is 1 in that clock. Each trial is the bits already decided, plus the bit under test set to 1.
- R5: The result equals the input code whenever the comparator is 1 exactly for trials at or below the input. A full-scale input gives 8'hFF and a ground input gives 8'h00.
- R6: `done_o` is a one-cycle pulse in the cycle in which `result_o` takes the new code. At all other times `result_o` holds its value.
- R7: A change of `sel_i` between two nonzero codes during a conversion does not affect that conversion. The next conversion uses the new input.
- R8: Setting `sel_i` to 2'b00 during a conversion aborts it, including in its final step. No `done_o` follows, and `result_o` keeps the earlier code.
- R9: `dac_code_o` is 8'h00 whenever no conversion is in progress.
- R10: After reset, `result_o` is 8'h00, `done_o` is 0, `dac_code_o` is 8'h00 and `mux_sel_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 2 | Input select: 00 off, 01/10/11 inputs 0/1/2 |
| cmp_i | input | 1 | Comparator answer: 1 when input is at or above trial code |
| mux_sel_o | output | 2 | Analog multiplexer input number |
| dac_code_o | output | 8 | Trial code to the DAC |
| pdn_o | output | 1 | Power-down request to the analog front end |
| result_o | output | 8 | Last completed conversion code |
| done_o | output | 1 | One-cycle pulse when `result_o` is written |

## Verification
Two functions can fall in the same cycle: the final search step, which would write the result, and a power-down request that aborts the conversion. The bench finds the first trial of a conversion by waiting for 8'h80 on the DAC code. It then steps exactly seven clocks to the last trial and sets the select to 00 in that cycle. The abort is judged correct when no done pulse follows and the result still holds the code of the previous conversion. A selection change against a running conversion is provoked the same way, and it is judged by which input's value appears in the next two results.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Select codes on the control input
  typedef enum logic [1:0] {
    SEL_OFF = 2'b00,
    SEL_IN0 = 2'b01,
    SEL_IN1 = 2'b10,
    SEL_IN2 = 2'b11
  } adc_sel_e;

  // Input number addressed by a nonzero select code
  function automatic logic [1:0] sel_to_chan(input logic [1:0] sel);
    logic [1:0] chan;
    unique case (sel)
      SEL_IN0: chan = 2'd0;
      SEL_IN1: chan = 2'd1;
      SEL_IN2: chan = 2'd2;
      default: chan = 2'd0;
    endcase
    return chan;
  endfunction

endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
  parameter int TICK_CYCLES = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign tick_o = en_i && (cnt == LAST);

  // Counter is held at zero while disabled, so enabling restarts the period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en_i || tick_o) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/adc_chan_select.sv
module adc_chan_select
  import adc_seq_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int CH_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             load_i,
  output logic             en_o,
  output logic [CH_W-1:0]  chan_o
);
  logic [CH_W-1:0] chan_q;

  assign en_o   = (sel_i != '0);
  assign chan_o = chan_q;

  // Input number is captured only when a conversion starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
    end else if (load_i) begin
      chan_q <= CH_W'(sel_to_chan(2'(sel_i)));
    end
  end
endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              cmp_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] trial_o,
  output logic              fin_o,
  output logic [DATA_W-1:0] code_o
);
  localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

  logic              busy_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] trial_q;
  logic [DATA_W-1:0] resolved;

  // One-hot weight of a bit position
  function automatic logic [DATA_W-1:0] weight(input logic [IDX_W-1:0] k);
    logic [DATA_W-1:0] w;
    w = '0;
    w[k] = 1'b1;
    return w;
  endfunction

  // Decide the bit under test from the comparator answer
  function automatic logic [DATA_W-1:0] decide(input logic [DATA_W-1:0] trial,
                                               input logic [IDX_W-1:0]  k,
                                               input logic              keep);
    return keep ? trial : (trial & ~weight(k));
  endfunction

  assign resolved = decide(trial_q, idx_q, cmp_i);
  assign busy_o   = busy_q;
  assign trial_o  = trial_q;
  assign fin_o    = busy_q && !abort_i && (idx_q == '0);
  assign code_o   = resolved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      trial_q <= '0;
    end else if (abort_i) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      trial_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q  <= 1'b1;
      idx_q   <= TOP_IDX;
      trial_q <= weight(TOP_IDX);
    end else if (busy_q) begin
      if (idx_q == '0) begin
        busy_q  <= 1'b0;
        trial_q <= '0;
      end else begin
        idx_q   <= idx_q - IDX_W'(1);
        trial_q <= resolved | weight(idx_q - IDX_W'(1));
      end
    end
  end
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq #(
  parameter int TICK_CYCLES = 1_000_000,
  parameter int DATA_W      = 8,
  parameter int SEL_W       = 2,
  parameter int NUM_IN      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sel_i,
  input  logic              cmp_i,
  output logic [1:0]        mux_sel_o,
  output logic [7:0]        dac_code_o,
  output logic              pdn_o,
  output logic [7:0]        result_o,
  output logic              done_o
);
  localparam int CH_W = (NUM_IN > 2) ? $clog2(NUM_IN) : 1;

  // Named internal events, also observed by the bound checker
  logic              conv_en;
  logic              tick_evt;
  logic              conv_start;
  logic              conv_abort;
  logic              sar_busy;
  logic              sar_fin;
  logic [DATA_W-1:0] sar_code;
  logic [DATA_W-1:0] sar_trial;
  logic [CH_W-1:0]   chan;
  logic [DATA_W-1:0] result_q;
  logic              done_q;

  assign conv_start = tick_evt && !sar_busy;
  assign conv_abort = sar_busy && !conv_en;

  adc_tick_gen #(
    .TICK_CYCLES(TICK_CYCLES)
  ) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (conv_en),
    .tick_o(tick_evt)
  );

  adc_chan_select #(
    .SEL_W(SEL_W),
    .CH_W (CH_W)
  ) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_i (SEL_W'(sel_i)),
    .load_i(conv_start),
    .en_o  (conv_en),
    .chan_o(chan)
  );

  adc_sar_engine #(
    .DATA_W(DATA_W)
  ) u_sar (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(conv_start),
    .abort_i(conv_abort),
    .cmp_i  (cmp_i),
    .busy_o (sar_busy),
    .trial_o(sar_trial),
    .fin_o  (sar_fin),
    .code_o (sar_code)
  );

  // Result written in one step at the end of the search
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= sar_fin;
      if (sar_fin) begin
        result_q <= sar_code;
      end
    end
  end

  assign pdn_o      = !conv_en;
  assign mux_sel_o  = 2'(chan);
  assign dac_code_o = 8'(sar_trial);
  assign result_o   = 8'(result_q);
  assign done_o     = done_q;
endmodule

// File: rtl/adc_sar_seq_checker.sv
module adc_sar_seq_checker #(
  parameter int DATA_W = 8,
  parameter int NUM_IN = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pdn_o,
  input logic       done_o,
  input logic [7:0] result_o,
  input logic [7:0] dac_code_o,
  input logic [1:0] mux_sel_o,
  input logic       conv_start,
  input logic       sar_busy
);
  localparam logic [7:0] FIRST_TRIAL = 8'(1 << (DATA_W - 1));

  assert_no_start_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pdn_o |-> !conv_start);

  assert_chan_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(mux_sel_o) < NUM_IN);

  assert_first_trial_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> (dac_code_o == FIRST_TRIAL));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  assert_mux_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sar_busy) && sar_busy) |-> $stable(mux_sel_o));

  assert_abort_no_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pdn_o && sar_busy) |=> !done_o);

  assert_idle_dac_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sar_busy) |-> (dac_code_o == 8'h00));
endmodule

bind adc_sar_seq adc_sar_seq_checker #(
  .DATA_W(DATA_W),
  .NUM_IN(NUM_IN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pdn_o     (pdn_o),
  .done_o    (done_o),
  .result_o  (result_o),
  .dac_code_o(dac_code_o),
  .mux_sel_o (mux_sel_o),
  .conv_start(conv_start),
  .sar_busy  (sar_busy)
);

// File: tb/adc_sar_seq_bench.sv
module adc_sar_seq_bench;
  localparam int LIM = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       cmp;
  logic [1:0] mux_sel;
  logic [7:0] dac_code;
  logic       pdn;
  logic [7:0] result;
  logic       done;

  logic [7:0] vin [0:3];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_sar_seq #(.TICK_CYCLES(LIM)) u_adc_sar_seq (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .cmp_i(cmp),
    .mux_sel_o(mux_sel), .dac_code_o(dac_code), .pdn_o(pdn),
    .result_o(result), .done_o(done)
  );

  // Behavioural front end: selected input compared against trial code
  always_comb cmp = (vin[mux_sel] >= dac_code);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count rising edges until done is seen at a falling edge
  task automatic edges_to_done(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!done && n < 4 * LIM);
  endtask

  task automatic wait_first_trial();
    int guard = 0;
    while (dac_code != 8'h80 && guard < 4 * LIM) begin
      @(negedge clk);
      guard++;
    end
  endtask

  function automatic int exp_trial(input int v, input int k);
    return (v & ((255 << (k + 1)) & 255)) | (1 << k);
  endfunction

  initial begin
    int n;
    int prev;
    vin[0] = 8'd0; vin[1] = 8'd0; vin[2] = 8'd0; vin[3] = 8'd0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(result == 8'h00, "R10 result", result, 0);
    check(done == 1'b0, "R10 done", done, 0);
    check(dac_code == 8'h00, "R10 dac", dac_code, 0);
    check(mux_sel == 2'd0, "R10 mux", mux_sel, 0);
    check(pdn == 1'b1, "R1 pdn at off", pdn, 1);
    rst_n = 1'b1;
    repeat (2 * LIM) @(negedge clk);
    check(done == 1'b0 && result == 8'h00, "R1 no conversion while off", result, 0);

    // R3 first conversion after enable
    vin[0] = 8'd77;
    sel = 2'b01;
    #1 check(pdn == 1'b0, "R1 pdn released", pdn, 0);
    edges_to_done(n);
    check(n == LIM + 8, "R3 first done latency", n, LIM + 8);
    check(result == 8'd77, "R5 first result", result, 77);

    // R5 R2 R3: sweep all codes on every input
    for (int ch = 0; ch < 3; ch++) begin
      sel = 2'(ch + 1);
      for (int v = 0; v < 256; v++) begin
        vin[0] = 8'(v ^ 8'h3C);
        vin[1] = 8'(~v);
        vin[2] = 8'(v + 91);
        vin[ch] = 8'(v);
        edges_to_done(n);
        if (v > 0 || ch == 0) check(n == LIM, "R3 period", n, LIM);
        check(result == 8'(v), "R5 sweep code", result, v);
        check(mux_sel == 2'(ch), "R2 mux select", mux_sel, ch);
      end
    end

    // R4 trial sequence for one conversion
    vin[2] = 8'hA5;
    wait_first_trial();
    for (int k = 7; k >= 0; k--) begin
      check(dac_code == 8'(exp_trial(165, k)), "R4 trial code", dac_code, exp_trial(165, k));
      @(negedge clk);
    end
    check(done == 1'b1 && result == 8'hA5, "R4 result after search", result, 165);
    @(negedge clk);
    check(dac_code == 8'h00, "R9 idle dac", dac_code, 0);

    // R7 select change during conversion
    vin[0] = 8'd10; vin[1] = 8'd20; vin[2] = 8'd30;
    sel = 2'b11;
    edges_to_done(n);
    wait_first_trial();
    sel = 2'b10;
    @(negedge clk);
    check(mux_sel == 2'd2, "R7 mux held", mux_sel, 2);
    edges_to_done(n);
    check(result == 8'd30, "R7 old input used", result, 30);
    edges_to_done(n);
    check(result == 8'd20, "R7 new input next", result, 20);

    // R8 abort in the middle of a conversion
    prev = result;
    vin[1] = 8'd200;
    wait_first_trial();
    sel = 2'b00;
    #1 check(pdn == 1'b1, "R1 pdn on disable", pdn, 1);
    for (int i = 0; i < 3 * LIM; i++) begin
      @(negedge clk);
      if (done) check(0, "R8 no done after abort", done, 0);
    end
    check(result == 8'(prev), "R8 result kept", result, prev);
    check(dac_code == 8'h00, "R9 dac after abort", dac_code, 0);

    // R3 re-enable restarts the period
    sel = 2'b10;
    edges_to_done(n);
    check(n == LIM + 8, "R3 latency after re-enable", n, LIM + 8);
    check(result == 8'd200, "R5 after re-enable", result, 200);

    // R8 abort coinciding with the final search step
    prev = result;
    vin[1] = 8'd3;
    wait_first_trial();
    repeat (7) @(negedge clk);
    check(dac_code == 8'(exp_trial(3, 0)), "R4 last trial", dac_code, exp_trial(3, 0));
    sel = 2'b00;
    @(negedge clk);
    check(done == 1'b0, "R8 final-step abort no done", done, 0);
    repeat (LIM) @(negedge clk);
    check(result == 8'(prev), "R8 final-step result kept", result, prev);

    // R5 extremes via full-scale and ground inputs
    vin[0] = 8'hFF;
    sel = 2'b01;
    edges_to_done(n);
    check(result == 8'hFF, "R5 full scale", result, 255);
    vin[0] = 8'h00;
    edges_to_done(n);
    check(result == 8'h00, "R5 ground", result, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule